// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's complement operands of width N and returns the full 2N-bit product. It needs no sign fix-up at the end. It takes one step per clock. In each step it reads two adjacent bits of the multiplier, one from the current low end and one just shifted out. From that pair it chooses to add the multiplicand to a running accumulator, subtract it, or leave the accumulator alone. It then shifts the accumulator, the multiplier register and the saved bit right by one place as a single arithmetic shift.

A caller drives the operands and pulses `start` while the block is idle. `busy` rises and the operands are captured. Exactly N clock edges later `busy` falls and `done` pulses for one cycle with the product on `product`. The product stays there until the next accepted start. A start pulse that arrives while the block is busy has no effect. The width N is a parameter and defaults to 8. Widths such as 5 are supported as well.

Top module: `booth_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared: after reset `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` high at an edge while idle captures `mcand` and `mplier`, and `busy` is 1 in the next cycle. The operands may change afterwards without effect.
- R3: After an accepted start, `busy` stays high for exactly N cycles. `done` rises in the cycle after the N-th edge that follows the start edge, and `busy` and `done` are never high together.
- R4: `done` is high for exactly one cycle per multiplication.
- R5: When `done` is high, `product` equals the signed product mcand × mplier as a 2N-bit two's complement value. The upper N bits come from the accumulator and the lower N bits from the multiplier register.
- R6: A `start` pulse while `busy` is high is ignored: the result and the completion cycle are those of the original operands.
- R7: The most negative operand value (-2^(N-1)) is handled correctly as multiplicand, as multiplier, or both. This relies on a one-bit guard extension of the accumulator.
- R8: With N = 5, multiplicand 11001 (-7) and multiplier 00101 (5) give product 1111011101 (-35).
- R9: After `done`, `product` holds its value while idle until the next accepted start.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only while idle |
| mcand | input | N | Multiplicand, signed two's complement |
| mplier | input | N | Multiplier, signed two's complement |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Signed product |

## Verification
The most negative multiplicand matters most. A design without the guard bit would overflow the accumulator when it subtracts -2^(N-1), and it would return a product with the wrong sign. A logical shift in place of the arithmetic one would corrupt every negative partial product. An off-by-one step count would give a product scaled by two and a `done` pulse in the wrong cycle. Both show up in the exhaustive 5-bit sweep and the randomised 8-bit runs. A start pulse injected mid-run with different operands would catch a design that reloads while busy.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package booth_pkg;

    // Action chosen for one step from the scanned bit pair
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } booth_act_e;

    // Controller phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } booth_phase_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-2 Booth recoder: maps the current multiplier LSB and the bit
// shifted out in the previous step to an add, subtract or hold action.
// Assumes: purely combinational; the caller gates it with its step enable.
module booth_recode
    import booth_pkg::*;
(
    input  logic       lsb,
    input  logic       prev,
    output booth_act_e act
);

    // Decode the pair: 10 starts a run of ones, 01 ends one
    always_comb begin
        unique case ({lsb, prev})
            2'b10:   act = ACT_SUB;
            2'b01:   act = ACT_ADD;
            default: act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
// Step sequencer: accepts a start while idle, counts N steps, then
// returns to idle and emits a one-cycle completion pulse.
// Assumes: synchronous active-low reset; N >= 2.
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    booth_phase_e   phase;
    logic [CW-1:0]  cnt;

    assign busy = (phase == PH_RUN);
    assign load = (phase == PH_IDLE) && start;
    assign step = busy;

    // Phase, step counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else if (step) begin
                if (cnt == LAST) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: completion lasts a single cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: busy and done never overlap
    a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: completion only follows a running cycle
    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R3: counter stays inside the step window
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6: a start while running does not restart the count
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/booth_datapath.sv
// Booth datapath: guard-extended accumulator, multiplier shift register
// and the saved low bit. Each step adds, subtracts or holds, then shifts
// the combined register right arithmetically by one place.
// Assumes: load and step are never high together (controller guarantees).
module booth_datapath
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);

    localparam int AW = N + 1;   // accumulator with one guard bit

    logic [AW-1:0] acc;
    logic [AW-1:0] mreg;
    logic [N-1:0]  qreg;
    logic          qprev;
    logic [AW-1:0] sum;
    booth_act_e    act;

    booth_recode u_rec (
        .lsb  (qreg[0]),
        .prev (qprev),
        .act  (act)
    );

    // Add, subtract via two's complement, or pass through
    always_comb begin
        unique case (act)
            ACT_ADD: sum = acc + mreg;
            ACT_SUB: sum = acc + (~mreg + 1'b1);
            default: sum = acc;
        endcase
    end

    // Operand capture and one arithmetic right shift per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            mreg  <= '0;
            qreg  <= '0;
            qprev <= 1'b0;
        end else if (load) begin
            acc   <= '0;
            mreg  <= {mcand[N-1], mcand};
            qreg  <= mplier;
            qprev <= 1'b0;
        end else if (step) begin
            acc   <= {sum[AW-1], sum[AW-1:1]};
            qreg  <= {sum[0], qreg[N-1:1]};
            qprev <= qreg[0];
        end
    end

    assign product = {acc[N-1:0], qreg};

    // R2: a load clears the accumulator and captures the multiplier
    a_r2_load_state: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc == '0 && !qprev && qreg == $past(mplier)));

    // R6: the multiplicand register changes only on a load
    a_r6_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mreg));

    // R9: with no load and no step the product is frozen
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(product));

    // R5: shift moves the old multiplier LSB into the saved bit
    a_r5_shift_bit: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (qprev == $past(qreg[0])));

endmodule

// File: rtl/booth_mult.sv
// Top of the sequential Booth signed multiplier: joins the step
// sequencer and the datapath. One add/subtract/hold plus one shift per
// cycle, N cycles per product.
// Assumes: synchronous active-low reset; N >= 2.
module booth_mult #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);

    logic load;
    logic step;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_datapath #(.N(N)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    // R2: an accepted start always leads to busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: tb/sim_booth_mult.sv
`timescale 1ns/1ps
module sim_booth_mult;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        st8 = 1'b0;
    logic [7:0]  mc8 = '0, mp8 = '0;
    logic        busy8, done8;
    logic [15:0] prod8;

    logic        st5 = 1'b0;
    logic [4:0]  mc5 = '0, mp5 = '0;
    logic        busy5, done5;
    logic [9:0]  prod5;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    booth_mult #(.N(8)) u0 (.clk(clk), .rst_n(rst_n), .start(st8),
        .mcand(mc8), .mplier(mp8), .busy(busy8), .done(done8), .product(prod8));

    booth_mult #(.N(5)) u1 (.clk(clk), .rst_n(rst_n), .start(st5),
        .mcand(mc5), .mplier(mp5), .busy(busy5), .done(done5), .product(prod5));

    function automatic logic [15:0] ref8(logic [7:0] a, logic [7:0] b);
        longint x = longint'($signed(a)) * longint'($signed(b));
        return x[15:0];
    endfunction

    function automatic logic [9:0] ref5(logic [4:0] a, logic [4:0] b);
        longint x = longint'($signed(a)) * longint'($signed(b));
        return x[9:0];
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One 8-bit multiplication; disturb injects a start with other operands mid-run
    task automatic go8(logic [7:0] a, logic [7:0] b, bit disturb, bit hold);
        logic [15:0] e = ref8(a, b);
        int cyc = 0;
        @(negedge clk); st8 = 1'b1; mc8 = a; mp8 = b;
        @(negedge clk); st8 = 1'b0; mc8 = ~a; mp8 = b ^ 8'h5a;
        chk(busy8 == 1'b1, "R2", busy8, 1);
        while (!done8 && cyc < 40) begin
            if (disturb && cyc == 3) st8 = 1'b1;
            chk(!(busy8 && done8), "R3", {busy8, done8}, 2'b10);
            @(negedge clk); st8 = 1'b0; cyc++;
        end
        chk(cyc == 8, "R3", cyc, 8);
        chk(busy8 == 1'b0, "R3", busy8, 0);
        chk(prod8 == e, disturb ? "R6" : "R5", prod8, e);
        @(negedge clk);
        chk(done8 == 1'b0, "R4", done8, 0);
        if (hold) begin
            repeat (3) @(negedge clk);
            chk(prod8 == e && !busy8, "R9", prod8, e);
        end
    endtask

    task automatic go5(logic [4:0] a, logic [4:0] b, string req);
        logic [9:0] e = ref5(a, b);
        int cyc = 0;
        @(negedge clk); st5 = 1'b1; mc5 = a; mp5 = b;
        @(negedge clk); st5 = 1'b0; mc5 = '0; mp5 = '0;
        while (!done5 && cyc < 30) begin
            @(negedge clk); cyc++;
        end
        chk(cyc == 5, "R3", cyc, 5);
        chk(prod5 == e, req, prod5, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1b00c5));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy8 && !done8 && prod8 == '0, "R1", prod8, 0);
        chk(!busy5 && !done5 && prod5 == '0, "R1", prod5, 0);
        rst_n = 1'b1;

        // R8: worked 5-bit example
        go5(5'b11001, 5'b00101, "R8");
        chk(prod5 == 10'b1111011101, "R8", prod5, 10'b1111011101);

        // R7: most negative operands
        go8(8'h80, 8'h80, 1'b0, 1'b0);
        chk(prod8 == 16'h4000, "R7", prod8, 16'h4000);
        go8(8'h80, 8'h7f, 1'b0, 1'b0);
        go8(8'h7f, 8'h80, 1'b0, 1'b0);
        go8(8'h80, 8'hff, 1'b0, 1'b1);
        go8(8'h00, 8'h80, 1'b0, 1'b0);
        go8(8'hff, 8'hff, 1'b0, 1'b0);

        // R6: start while busy ignored
        go8(8'd93, 8'hc3, 1'b1, 1'b1);
        go8(8'h81, 8'h55, 1'b1, 1'b0);

        // R5/R7: exhaustive 5-bit sweep
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                go5(5'(i), 5'(j), "R5");

        // R5: random 8-bit operands
        for (int k = 0; k < 400; k++)
            go8(8'($urandom), 8'($urandom), (k % 17) == 0, (k % 29) == 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule